// File: doc/BRIEF.md
# Home-Node Coherence Directory with Split-Phase Memory

This block is the home node for a set of cache lines in a broadcast coherence protocol with owned, exclusive and non-owner line states. Every line has a directory entry. Caches send three kinds of request to it: a shared read, an exclusive read and a put (eviction). They also send an unblock when a transfer has finished, and writeback messages after a put. The directory answers requesters on a response port and broadcasts read requests to the other caches on a forward port. It reaches off-chip memory through a split-phase port. Read and writeback commands go out on that port, and read data or writeback acknowledgements come back later on a separate reply input.

Memory is split-phase. While a read is outstanding, the line sits in a blocked-and-waiting state. A small associative transaction table holds the response kind for that line and also a copy of the line state, and the directory reads the state from this copy while the entry is live. When the memory data arrives, the directory sends the data to the requester named in the memory reply, frees the entry and leaves the waiting state. A request that reaches a line in any non-stable state is not served. It is sent back on a recycle port so that the fabric can retry it later.

Line states: EXCL (exclusive at home, the reset state), NOWN (no owner at home), OWN (owner), NOWN_BLK and OWN_BLK (blocked for an unblock), NOWN_BLK_MEM and OWN_BLK_MEM (blocked and waiting for memory data), NOWN_MEM and OWN_MEM (waiting for memory data only), WBK (blocked on a writeback), WBK_TO_E and WBK_TO_O (waiting for a memory write ack). Transitions:
- EXCL --read--> NOWN_BLK_MEM
- OWN --excl read--> NOWN_BLK_MEM
- OWN --shared read--> OWN_BLK_MEM
- NOWN --read--> NOWN_BLK
- EXCL, NOWN or OWN --put--> WBK
- *_BLK_MEM --data--> *_BLK
- *_BLK_MEM --unblock--> *_MEM
- *_MEM --data--> NOWN or OWN
- NOWN_BLK --unblock--> NOWN
- OWN_BLK --unblock--> OWN
- WBK --dirty--> WBK_TO_E
- WBK --exclusive dirty--> WBK_TO_O
- WBK --clean--> OWN
- WBK_TO_E --ack--> EXCL
- WBK_TO_O --ack--> OWN

Top module: `coh_home_dir`

## Requirements
- R1: After reset every line is EXCL, so a first read of any line is answered with kind DATA_EXCL (1), and no output valid is high.
- R2: A read (req_kind 0 shared, 1 exclusive) on an EXCL line issues a memory read (mreq_kind 0) one cycle later carrying the line and requester, allocates a table entry recording DATA_EXCL, and moves the line to NOWN_BLK_MEM.
- R3: On an OWN line an exclusive read records DATA (0) and goes to NOWN_BLK_MEM, and a shared read records DATA and goes to OWN_BLK_MEM. On a NOWN line a read issues only a forward, with no memory read, and goes to NOWN_BLK.
- R4: Every accepted read is forwarded one cycle later with fwd_mask set for every cache except the requester, and only when NCACHE is above 1.
- R5: Memory read data (mrd_kind 0) in NOWN_BLK_MEM or OWN_BLK_MEM produces, one cycle later, a response of the recorded kind to mrd_src carrying mrd_data, dirty 0 and ack count 1. The entry is then freed and the line goes to NOWN_BLK or OWN_BLK.
- R6: An unblock (unb_kind 0) moves NOWN_BLK_MEM to NOWN_MEM and OWN_BLK_MEM to OWN_MEM, and moves NOWN_BLK and OWN_BLK to NOWN and OWN. Later data in NOWN_MEM or OWN_MEM frees the entry with no response and lands on NOWN or OWN.
- R7: Any request to a line in a non-stable state is echoed on the recycle port one cycle later. It produces no memory request, no forward and no response.
- R8: A put (req_kind 2) on a stable line sends a WB_ACK (2) response to the requester and moves the line to WBK.
- R9: In WBK, a dirty writeback (unb_kind 2) issues a memory write (mreq_kind 1) with unb_data and goes to WBK_TO_E. An exclusive dirty writeback (3) does the same but goes to WBK_TO_O. A clean writeback (1) goes to OWN with no memory traffic.
- R10: A memory write ack (mrd_kind 1) moves WBK_TO_E to EXCL and WBK_TO_O to OWN, with no response.
- R11: A memory reply of kind 2 or 3 raises mrd_err one cycle later and changes no line.
- R12: When the table is full, a request that needs an entry holds req_ready low and is accepted, not dropped, once an entry is freed.
- R13: One event is taken per cycle. A memory reply wins over an unblock, which wins over a request, and unb_ready and req_ready drop while a higher-priority input is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Cache request valid |
| req_ready | output | 1 | Request accepted this cycle |
| req_kind | input | 2 | 0 shared read, 1 exclusive read, 2 put |
| req_line | input | LW | Line index |
| req_src | input | CW | Requesting cache |
| unb_valid | input | 1 | Unblock/writeback message valid |
| unb_ready | output | 1 | Unblock/writeback accepted |
| unb_kind | input | 2 | 0 unblock, 1 clean, 2 dirty, 3 exclusive dirty |
| unb_line | input | LW | Line index |
| unb_data | input | DW | Writeback data |
| mrd_valid | input | 1 | Memory reply valid (always taken) |
| mrd_kind | input | 2 | 0 read data, 1 write ack, others invalid |
| mrd_line | input | LW | Line index |
| mrd_src | input | CW | Original requester carried by the read |
| mrd_data | input | DW | Read data |
| mreq_valid | output | 1 | Memory command valid |
| mreq_kind | output | 2 | 0 read, 1 write |
| mreq_line | output | LW | Line index |
| mreq_src | output | CW | Requester, for reads |
| mreq_data | output | DW | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_kind | output | 2 | 0 DATA, 1 DATA_EXCL, 2 WB_ACK |
| rsp_dest | output | CW | Destination cache |
| rsp_data | output | DW | Response data |
| rsp_dirty | output | 1 | Dirty flag, always clear |
| rsp_acks | output | 2 | Ack count |
| fwd_valid | output | 1 | Forward valid |
| fwd_kind | output | 2 | Forwarded request kind |
| fwd_line | output | LW | Line index |
| fwd_src | output | CW | Original requester |
| fwd_mask | output | NCACHE | Destination caches |
| rcy_valid | output | 1 | Recycled request valid |
| rcy_kind | output | 2 | Recycled request kind |
| rcy_line | output | LW | Recycled line |
| rcy_src | output | CW | Recycled requester |
| mrd_err | output | 1 | Invalid memory reply kind seen |

## Verification
The ready outputs are combinational and belong to the current cycle. Every other result (memory command, response, forward, recycle and error) is registered and appears exactly one cycle after the rising edge that accepts the event. The bench drives inputs on the falling edge and reads the ready signals 1 ns later. It reads the registered outputs at the next falling edge after the accepting rising edge, which is the only cycle in which they are valid. Line state is never read directly. It is inferred through the ports from the memory command and response kind of a follow-up request, or from whether that request is recycled.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;

    typedef enum logic [3:0] {
        S_EXCL         = 4'd0,
        S_NOWN         = 4'd1,
        S_OWN          = 4'd2,
        S_NOWN_BLK     = 4'd3,
        S_OWN_BLK      = 4'd4,
        S_NOWN_BLK_MEM = 4'd5,
        S_OWN_BLK_MEM  = 4'd6,
        S_NOWN_MEM     = 4'd7,
        S_OWN_MEM      = 4'd8,
        S_WBK          = 4'd9,
        S_WBK_TO_E     = 4'd10,
        S_WBK_TO_O     = 4'd11
    } line_st_e;

    typedef enum logic [1:0] {
        RQ_RD_SHR  = 2'd0,
        RQ_RD_EXCL = 2'd1,
        RQ_PUT     = 2'd2
    } req_kind_e;

    typedef enum logic [1:0] {
        UB_UNBLOCK   = 2'd0,
        UB_WB_CLEAN  = 2'd1,
        UB_WB_DIRTY  = 2'd2,
        UB_WB_XDIRTY = 2'd3
    } unb_kind_e;

    typedef enum logic [1:0] {
        MK_READ = 2'd0,
        MK_WB   = 2'd1
    } mem_kind_e;

    typedef enum logic [1:0] {
        RS_DATA      = 2'd0,
        RS_DATA_EXCL = 2'd1,
        RS_WB_ACK    = 2'd2
    } rsp_kind_e;

endpackage

// File: rtl/coh_dir_array.sv
module coh_dir_array
    import coh_dir_pkg::*;
#(
    parameter int LINES = 16,
    localparam int LW = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] rd_line,
    output line_st_e      rd_st,
    input  logic          wr_en,
    input  logic [LW-1:0] wr_line,
    input  line_st_e      wr_st
);

    line_st_e st_q [LINES];

    assign rd_st = st_q[rd_line];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) st_q[i] <= S_EXCL;
        end else if (wr_en) begin
            st_q[wr_line] <= wr_st;
        end
    end

endmodule

// File: rtl/coh_txn_table.sv
module coh_txn_table
    import coh_dir_pkg::*;
#(
    parameter int DEPTH = 2,
    parameter int LW    = 4,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] lk_line,
    output logic          hit,
    output line_st_e      hit_st,
    output rsp_kind_e     hit_rk,
    output logic          full,
    input  logic          alloc_en,
    input  logic [LW-1:0] alloc_line,
    input  rsp_kind_e     alloc_rk,
    input  line_st_e      alloc_st,
    input  logic          upd_en,
    input  line_st_e      upd_st,
    input  logic          free_en
);

    logic [DEPTH-1:0] vld_q;
    logic [LW-1:0]    line_q [DEPTH];
    rsp_kind_e        rk_q   [DEPTH];
    line_st_e         st_q   [DEPTH];
    logic [DEPTH-1:0] hit_vec;
    logic [IW-1:0]    hit_idx;
    logic [IW-1:0]    free_idx;

    always_comb begin
        hit_idx  = '0;
        free_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            hit_vec[i] = vld_q[i] && (line_q[i] == lk_line);
            if (hit_vec[i]) hit_idx = IW'(i);
        end
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!vld_q[i]) free_idx = IW'(i);
        end
    end

    assign hit    = |hit_vec;
    assign hit_st = st_q[hit_idx];
    assign hit_rk = rk_q[hit_idx];
    assign full   = &vld_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                line_q[i] <= '0;
                rk_q[i]   <= RS_DATA;
                st_q[i]   <= S_EXCL;
            end
        end else begin
            if (alloc_en) begin
                vld_q[free_idx]  <= 1'b1;
                line_q[free_idx] <= alloc_line;
                rk_q[free_idx]   <= alloc_rk;
                st_q[free_idx]   <= alloc_st;
            end
            if (upd_en && hit) st_q[hit_idx] <= upd_st;
            if (free_en && hit) vld_q[hit_idx] <= 1'b0;
        end
    end

    // R12: an allocation never lands on a full table
    assert_alloc_room_R12: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> !full) else $error("table allocation while full");

    // R2: a line never owns two live entries
    assert_alloc_unique_R2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> !hit) else $error("duplicate table entry");

    // R6: a free always targets a live entry
    assert_free_hits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        free_en |-> hit) else $error("free without live entry");

    // R12: at most one entry per line after any cycle
    assert_single_hit_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec)) else $error("multiple entries hit");

endmodule

// File: rtl/coh_home_dir.sv
module coh_home_dir
    import coh_dir_pkg::*;
#(
    parameter int LINES     = 16,
    parameter int NCACHE    = 4,
    parameter int TXN_DEPTH = 2,
    parameter int DW        = 32,
    localparam int LW = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int CW = (NCACHE > 1) ? $clog2(NCACHE) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [LW-1:0]     req_line,
    input  logic [CW-1:0]     req_src,
    input  logic              unb_valid,
    output logic              unb_ready,
    input  logic [1:0]        unb_kind,
    input  logic [LW-1:0]     unb_line,
    input  logic [DW-1:0]     unb_data,
    input  logic              mrd_valid,
    input  logic [1:0]        mrd_kind,
    input  logic [LW-1:0]     mrd_line,
    input  logic [CW-1:0]     mrd_src,
    input  logic [DW-1:0]     mrd_data,
    output logic              mreq_valid,
    output logic [1:0]        mreq_kind,
    output logic [LW-1:0]     mreq_line,
    output logic [CW-1:0]     mreq_src,
    output logic [DW-1:0]     mreq_data,
    output logic              rsp_valid,
    output logic [1:0]        rsp_kind,
    output logic [CW-1:0]     rsp_dest,
    output logic [DW-1:0]     rsp_data,
    output logic              rsp_dirty,
    output logic [1:0]        rsp_acks,
    output logic              fwd_valid,
    output logic [1:0]        fwd_kind,
    output logic [LW-1:0]     fwd_line,
    output logic [CW-1:0]     fwd_src,
    output logic [NCACHE-1:0] fwd_mask,
    output logic              rcy_valid,
    output logic [1:0]        rcy_kind,
    output logic [LW-1:0]     rcy_line,
    output logic [CW-1:0]     rcy_src,
    output logic              mrd_err
);

    localparam bit HAS_PEERS = (NCACHE > 1);

    logic          ev_mem, ev_unb, ev_req_sel, req_fire, need_alloc;
    logic [LW-1:0] ev_line;
    line_st_e      arr_st, tb_st, cur_st, nxt_st;
    rsp_kind_e     tb_rk, al_rk, o_rkind;
    logic          tb_hit, tb_full;
    logic          st_we, al_en, fr_en;
    logic          o_mreq, o_rsp, o_fwd, o_rcy, o_err;
    mem_kind_e     o_mkind;
    logic [NCACHE-1:0] fwd_mask_n;

    // event arbitration: memory reply, then unblock, then request (R13)
    assign ev_mem     = mrd_valid;
    assign ev_unb     = unb_valid && !mrd_valid;
    assign ev_req_sel = !mrd_valid && !unb_valid;
    assign ev_line    = mrd_valid ? mrd_line : (unb_valid ? unb_line : req_line);

    assign cur_st     = tb_hit ? tb_st : arr_st;
    assign need_alloc = (req_kind != RQ_PUT) && ((cur_st == S_EXCL) || (cur_st == S_OWN));
    assign req_ready  = ev_req_sel && !(need_alloc && tb_full);
    assign unb_ready  = !mrd_valid;
    assign req_fire   = req_valid && req_ready;
    assign st_we      = ev_mem || ev_unb || req_fire;
    assign fwd_mask_n = ~(NCACHE'(1) << req_src);

    coh_dir_array #(.LINES(LINES)) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_line (ev_line),
        .rd_st   (arr_st),
        .wr_en   (st_we),
        .wr_line (ev_line),
        .wr_st   (nxt_st)
    );

    coh_txn_table #(.DEPTH(TXN_DEPTH), .LW(LW)) u_tbl (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_line    (ev_line),
        .hit        (tb_hit),
        .hit_st     (tb_st),
        .hit_rk     (tb_rk),
        .full       (tb_full),
        .alloc_en   (al_en),
        .alloc_line (ev_line),
        .alloc_rk   (al_rk),
        .alloc_st   (nxt_st),
        .upd_en     (st_we),
        .upd_st     (nxt_st),
        .free_en    (fr_en)
    );

    // next-state and action decode
    always_comb begin
        nxt_st  = cur_st;
        al_en   = 1'b0;
        al_rk   = RS_DATA;
        fr_en   = 1'b0;
        o_mreq  = 1'b0;
        o_mkind = MK_READ;
        o_rsp   = 1'b0;
        o_rkind = RS_DATA;
        o_fwd   = 1'b0;
        o_rcy   = 1'b0;
        o_err   = 1'b0;
        if (ev_mem) begin
            if (mrd_kind == MK_READ) begin
                unique case (cur_st)
                    S_NOWN_BLK_MEM: begin o_rsp = 1'b1; o_rkind = tb_rk; fr_en = 1'b1; nxt_st = S_NOWN_BLK; end
                    S_OWN_BLK_MEM:  begin o_rsp = 1'b1; o_rkind = tb_rk; fr_en = 1'b1; nxt_st = S_OWN_BLK;  end
                    S_NOWN_MEM:     begin fr_en = 1'b1; nxt_st = S_NOWN; end
                    S_OWN_MEM:      begin fr_en = 1'b1; nxt_st = S_OWN;  end
                    default: ;
                endcase
            end else if (mrd_kind == MK_WB) begin
                unique case (cur_st)
                    S_WBK_TO_E: nxt_st = S_EXCL;
                    S_WBK_TO_O: nxt_st = S_OWN;
                    default: ;
                endcase
            end else begin
                o_err = 1'b1;
            end
        end else if (ev_unb) begin
            unique case (cur_st)
                S_NOWN_BLK:     if (unb_kind == UB_UNBLOCK) nxt_st = S_NOWN;
                S_OWN_BLK:      if (unb_kind == UB_UNBLOCK) nxt_st = S_OWN;
                S_NOWN_BLK_MEM: if (unb_kind == UB_UNBLOCK) nxt_st = S_NOWN_MEM;
                S_OWN_BLK_MEM:  if (unb_kind == UB_UNBLOCK) nxt_st = S_OWN_MEM;
                S_WBK: begin
                    if (unb_kind == UB_WB_DIRTY) begin
                        o_mreq = 1'b1; o_mkind = MK_WB; nxt_st = S_WBK_TO_E;
                    end else if (unb_kind == UB_WB_XDIRTY) begin
                        o_mreq = 1'b1; o_mkind = MK_WB; nxt_st = S_WBK_TO_O;
                    end else if (unb_kind == UB_WB_CLEAN) begin
                        nxt_st = S_OWN;
                    end
                end
                default: ;
            endcase
        end else if (req_fire) begin
            unique case (cur_st)
                S_EXCL, S_OWN: begin
                    if (req_kind == RQ_PUT) begin
                        o_rsp = 1'b1; o_rkind = RS_WB_ACK; nxt_st = S_WBK;
                    end else begin
                        al_en  = 1'b1;
                        al_rk  = (cur_st == S_EXCL) ? RS_DATA_EXCL : RS_DATA;
                        o_mreq = 1'b1;
                        o_fwd  = 1'b1;
                        nxt_st = (cur_st == S_OWN && req_kind == RQ_RD_SHR) ? S_OWN_BLK_MEM : S_NOWN_BLK_MEM;
                    end
                end
                S_NOWN: begin
                    if (req_kind == RQ_PUT) begin
                        o_rsp = 1'b1; o_rkind = RS_WB_ACK; nxt_st = S_WBK;
                    end else begin
                        o_fwd = 1'b1; nxt_st = S_NOWN_BLK;
                    end
                end
                default: o_rcy = 1'b1;
            endcase
        end
    end

    assign rsp_dirty = 1'b0;

    // registered message formation: every output one cycle after its event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mreq_valid <= 1'b0; mreq_kind <= '0; mreq_line <= '0; mreq_src <= '0; mreq_data <= '0;
            rsp_valid  <= 1'b0; rsp_kind  <= '0; rsp_dest  <= '0; rsp_data <= '0; rsp_acks  <= '0;
            fwd_valid  <= 1'b0; fwd_kind  <= '0; fwd_line  <= '0; fwd_src  <= '0; fwd_mask  <= '0;
            rcy_valid  <= 1'b0; rcy_kind  <= '0; rcy_line  <= '0; rcy_src  <= '0;
            mrd_err    <= 1'b0;
        end else begin
            mreq_valid <= o_mreq;
            mreq_kind  <= o_mkind;
            mreq_line  <= ev_line;
            mreq_src   <= (o_mkind == MK_READ) ? req_src : '0;
            mreq_data  <= (o_mkind == MK_WB) ? unb_data : '0;
            rsp_valid  <= o_rsp;
            rsp_kind   <= o_rkind;
            rsp_dest   <= ev_mem ? mrd_src : req_src;
            rsp_data   <= ev_mem ? mrd_data : '0;
            rsp_acks   <= (o_rkind == RS_WB_ACK) ? 2'd0 : 2'd1;
            fwd_valid  <= o_fwd && HAS_PEERS;
            fwd_kind   <= req_kind;
            fwd_line   <= ev_line;
            fwd_src    <= req_src;
            fwd_mask   <= fwd_mask_n;
            rcy_valid  <= o_rcy;
            rcy_kind   <= req_kind;
            rcy_line   <= ev_line;
            rcy_src    <= req_src;
            mrd_err    <= o_err;
        end
    end

    // R5: a data response only follows a memory read reply
    assert_data_after_mem_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind != RS_WB_ACK) |-> $past(mrd_valid && mrd_kind == MK_READ))
        else $error("data response without memory data");

    // R7: a recycled request produces no other message
    assert_recycle_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rcy_valid |-> (!mreq_valid && !rsp_valid && !fwd_valid))
        else $error("recycled request was serviced");

    // R4: forward excludes the requester and reaches every other cache
    assert_fwd_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> (!fwd_mask[fwd_src] && $countones(fwd_mask) == NCACHE - 1))
        else $error("bad forward mask");

    // R9: a memory write follows an accepted writeback message
    assert_wb_after_unb_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq_valid && mreq_kind == MK_WB) |-> $past(unb_valid && unb_ready))
        else $error("memory write without writeback");

    // R11: the error flag follows an invalid memory reply kind
    assert_err_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mrd_err |-> $past(mrd_valid && mrd_kind[1]))
        else $error("spurious memory error");

    // R13: at most one event is consumed per cycle
    assert_one_event_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mrd_valid, unb_valid && unb_ready, req_valid && req_ready}))
        else $error("two events in one cycle");

endmodule

// File: tb/sim_coh_home_dir.sv
module sim_coh_home_dir;

    localparam int LW = 4;
    localparam int CW = 2;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, unb_valid = 1'b0, mrd_valid = 1'b0;
    logic [1:0]    req_kind = '0, unb_kind = '0, mrd_kind = '0;
    logic [LW-1:0] req_line = '0, unb_line = '0, mrd_line = '0;
    logic [CW-1:0] req_src = '0, mrd_src = '0;
    logic [DW-1:0] unb_data = '0, mrd_data = '0;
    logic          req_ready, unb_ready;
    logic          mreq_valid, rsp_valid, rsp_dirty, fwd_valid, rcy_valid, mrd_err;
    logic [1:0]    mreq_kind, rsp_kind, rsp_acks, fwd_kind, rcy_kind;
    logic [LW-1:0] mreq_line, fwd_line, rcy_line;
    logic [CW-1:0] mreq_src, rsp_dest, fwd_src, rcy_src;
    logic [DW-1:0] mreq_data, rsp_data;
    logic [3:0]    fwd_mask;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    coh_home_dir u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind), .req_line(req_line), .req_src(req_src),
        .unb_valid(unb_valid), .unb_ready(unb_ready), .unb_kind(unb_kind), .unb_line(unb_line), .unb_data(unb_data),
        .mrd_valid(mrd_valid), .mrd_kind(mrd_kind), .mrd_line(mrd_line), .mrd_src(mrd_src), .mrd_data(mrd_data),
        .mreq_valid(mreq_valid), .mreq_kind(mreq_kind), .mreq_line(mreq_line), .mreq_src(mreq_src), .mreq_data(mreq_data),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_dest(rsp_dest), .rsp_data(rsp_data),
        .rsp_dirty(rsp_dirty), .rsp_acks(rsp_acks),
        .fwd_valid(fwd_valid), .fwd_kind(fwd_kind), .fwd_line(fwd_line), .fwd_src(fwd_src), .fwd_mask(fwd_mask),
        .rcy_valid(rcy_valid), .rcy_kind(rcy_kind), .rcy_line(rcy_line), .rcy_src(rcy_src),
        .mrd_err(mrd_err)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_all();
        req_valid = 1'b0; unb_valid = 1'b0; mrd_valid = 1'b0;
    endtask

    // one accepting edge, then sample at the following falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        clear_all();
    endtask

    task automatic req(input logic [1:0] k, input logic [LW-1:0] l, input logic [CW-1:0] s);
        req_valid = 1'b1; req_kind = k; req_line = l; req_src = s;
        step();
    endtask

    task automatic unb(input logic [1:0] k, input logic [LW-1:0] l, input logic [DW-1:0] d);
        unb_valid = 1'b1; unb_kind = k; unb_line = l; unb_data = d;
        step();
    endtask

    task automatic mrd(input logic [1:0] k, input logic [LW-1:0] l, input logic [CW-1:0] s, input logic [DW-1:0] d);
        mrd_valid = 1'b1; mrd_kind = k; mrd_line = l; mrd_src = s; mrd_data = d;
        step();
    endtask

    task automatic t_reset();
        chk("R1 mreq_valid idle", mreq_valid, 0);
        chk("R1 rsp_valid idle", rsp_valid, 0);
        chk("R1 fwd_valid idle", fwd_valid, 0);
        chk("R1 rcy_valid idle", rcy_valid, 0);
        chk("R1 mrd_err idle", mrd_err, 0);
        chk("R1 req_ready", req_ready, 1);
    endtask

    task automatic t_excl_read();
        req(2'd0, 4'd1, 2'd2);
        chk("R2 mreq_valid", mreq_valid, 1);
        chk("R2 mreq_kind read", mreq_kind, 0);
        chk("R2 mreq_line", mreq_line, 1);
        chk("R2 mreq_src", mreq_src, 2);
        chk("R4 fwd_valid", fwd_valid, 1);
        chk("R4 fwd_mask", fwd_mask, 4'b1011);
        chk("R4 fwd_src", fwd_src, 2);
        chk("R2 no early rsp", rsp_valid, 0);
        req(2'd1, 4'd1, 2'd0);
        chk("R7 recycle in NOWN_BLK_MEM", rcy_valid, 1);
        chk("R7 recycle src", rcy_src, 0);
        chk("R7 recycle no mreq", mreq_valid, 0);
        mrd(2'd0, 4'd1, 2'd2, 32'hA5A5_0001);
        chk("R5 rsp_valid", rsp_valid, 1);
        chk("R1 rsp_kind DATA_EXCL", rsp_kind, 1);
        chk("R5 rsp_dest", rsp_dest, 2);
        chk("R5 rsp_data", rsp_data, 32'hA5A5_0001);
        chk("R5 rsp_dirty", rsp_dirty, 0);
        chk("R5 rsp_acks", rsp_acks, 1);
        req(2'd0, 4'd1, 2'd3);
        chk("R7 recycle in NOWN_BLK", rcy_valid, 1);
        unb(2'd0, 4'd1, '0);
        req(2'd1, 4'd1, 2'd0);
        chk("R3 NOWN read forwards", fwd_valid, 1);
        chk("R3 NOWN read no mreq", mreq_valid, 0);
        chk("R4 fwd_mask src0", fwd_mask, 4'b1110);
        unb(2'd0, 4'd1, '0);
    endtask

    task automatic t_put_dirty();
        req(2'd2, 4'd2, 2'd3);
        chk("R8 wb ack valid", rsp_valid, 1);
        chk("R8 wb ack kind", rsp_kind, 2);
        chk("R8 wb ack dest", rsp_dest, 3);
        chk("R8 no mreq", mreq_valid, 0);
        req(2'd0, 4'd2, 2'd1);
        chk("R7 recycle in WBK", rcy_valid, 1);
        unb(2'd2, 4'd2, 32'h77);
        chk("R9 dirty mreq_valid", mreq_valid, 1);
        chk("R9 dirty mreq_kind write", mreq_kind, 1);
        chk("R9 dirty mreq_line", mreq_line, 2);
        chk("R9 dirty mreq_data", mreq_data, 32'h77);
        req(2'd0, 4'd2, 2'd1);
        chk("R7 recycle in WBK_TO_E", rcy_valid, 1);
        mrd(2'd1, 4'd2, 2'd0, '0);
        chk("R10 ack no rsp", rsp_valid, 0);
        req(2'd0, 4'd2, 2'd1);
        chk("R10 read after ack", mreq_valid, 1);
        mrd(2'd0, 4'd2, 2'd1, 32'h22);
        chk("R10 WBK_TO_E lands EXCL", rsp_kind, 1);
        unb(2'd0, 4'd2, '0);
    endtask

    task automatic t_put_xdirty();
        req(2'd2, 4'd3, 2'd0);
        unb(2'd3, 4'd3, 32'h88);
        chk("R9 xdirty mreq write", mreq_valid && mreq_kind == 2'd1, 1);
        chk("R9 xdirty data", mreq_data, 32'h88);
        mrd(2'd1, 4'd3, 2'd0, '0);
        req(2'd0, 4'd3, 2'd0);
        chk("R3 OWN shared read mreq", mreq_valid, 1);
        mrd(2'd0, 4'd3, 2'd0, 32'h33);
        chk("R10 WBK_TO_O lands OWN (DATA)", rsp_kind, 0);
        chk("R3 OWN rsp_valid", rsp_valid, 1);
        req(2'd1, 4'd3, 2'd2);
        chk("R3 OWN_BLK recycles", rcy_valid, 1);
        unb(2'd0, 4'd3, '0);
        req(2'd1, 4'd3, 2'd1);
        chk("R3 OWN_BLK unblock to OWN", mreq_valid, 1);
        unb(2'd0, 4'd3, '0);
        req(2'd0, 4'd3, 2'd2);
        chk("R6 NOWN_MEM recycles", rcy_valid, 1);
        mrd(2'd0, 4'd3, 2'd1, 32'h44);
        chk("R6 late data no rsp", rsp_valid, 0);
        req(2'd0, 4'd3, 2'd2);
        chk("R6 lands NOWN fwd", fwd_valid, 1);
        chk("R6 lands NOWN no mreq", mreq_valid, 0);
        unb(2'd0, 4'd3, '0);
    endtask

    task automatic t_clean();
        req(2'd2, 4'd4, 2'd1);
        unb(2'd1, 4'd4, 32'h55);
        chk("R9 clean no mreq", mreq_valid, 0);
        req(2'd0, 4'd4, 2'd1);
        chk("R9 clean then read", mreq_valid, 1);
        mrd(2'd0, 4'd4, 2'd1, 32'h66);
        chk("R9 clean lands OWN", rsp_kind, 0);
        unb(2'd0, 4'd4, '0);
    endtask

    task automatic t_err();
        mrd(2'd2, 4'd5, 2'd0, '0);
        chk("R11 err kind2", mrd_err, 1);
        chk("R11 no rsp", rsp_valid, 0);
        mrd(2'd3, 4'd5, 2'd0, '0);
        chk("R11 err kind3", mrd_err, 1);
        req(2'd0, 4'd5, 2'd1);
        chk("R11 line unchanged read", mreq_valid, 1);
        mrd(2'd0, 4'd5, 2'd1, 32'h99);
        chk("R11 line still EXCL", rsp_kind, 1);
        unb(2'd0, 4'd5, '0);
    endtask

    task automatic t_full();
        req(2'd0, 4'd6, 2'd0);
        req(2'd0, 4'd7, 2'd1);
        req_valid = 1'b1; req_kind = 2'd0; req_line = 4'd8; req_src = 2'd2;
        #1 chk("R12 ready low when full", req_ready, 0);
        @(posedge clk); @(negedge clk);
        chk("R12 held request not issued", mreq_valid, 0);
        mrd_valid = 1'b1; mrd_kind = 2'd0; mrd_line = 4'd6; mrd_src = 2'd0; mrd_data = 32'h6;
        @(posedge clk); @(negedge clk);
        mrd_valid = 1'b0;
        chk("R12 free via data", rsp_valid, 1);
        #1 chk("R12 ready after free", req_ready, 1);
        @(posedge clk); @(negedge clk);
        clear_all();
        chk("R12 held request issued", mreq_valid, 1);
        chk("R12 held request line", mreq_line, 8);
        chk("R12 held request src", mreq_src, 2);
        mrd(2'd0, 4'd7, 2'd1, 32'h7);
        mrd(2'd0, 4'd8, 2'd2, 32'h8);
        unb(2'd0, 4'd6, '0);
        unb(2'd0, 4'd7, '0);
        unb(2'd0, 4'd8, '0);
    endtask

    task automatic t_arb();
        mrd_valid = 1'b1; mrd_kind = 2'd0; mrd_line = 4'd9; mrd_src = 2'd0; mrd_data = '0;
        unb_valid = 1'b1; unb_kind = 2'd0; unb_line = 4'd10;
        req_valid = 1'b1; req_kind = 2'd0; req_line = 4'd11; req_src = 2'd0;
        #1 chk("R13 unb_ready low under mem", unb_ready, 0);
        chk("R13 req_ready low under mem", req_ready, 0);
        @(posedge clk); @(negedge clk);
        mrd_valid = 1'b0;
        chk("R13 stray data ignored", rsp_valid, 0);
        #1 chk("R13 unb_ready", unb_ready, 1);
        chk("R13 req_ready low under unb", req_ready, 0);
        @(posedge clk); @(negedge clk);
        unb_valid = 1'b0;
        chk("R13 req waits", mreq_valid, 0);
        #1 chk("R13 req_ready free", req_ready, 1);
        @(posedge clk); @(negedge clk);
        clear_all();
        chk("R13 req served last", mreq_valid && mreq_line == 4'd11, 1);
        mrd(2'd0, 4'd11, 2'd0, '0);
        unb(2'd0, 4'd11, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_excl_read();
        t_put_dirty();
        t_put_xdirty();
        t_clean();
        t_err();
        t_full();
        t_arb();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule